// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard bookkeeper for a small machine with a handful of function units, each of which may be unpipelined. Instructions arrive one at a time, in program order, at the issue port. Each instruction names a target unit, a destination register, two source registers and an execution latency. The controller decides when each instruction may enter its unit. It then tells the unit when its operands may be fetched from the register file and when its result may be written back. There is no datapath. Execution is modelled by a per-unit countdown, and the outputs are grant vectors that a surrounding datapath would follow.

For every unit the controller records the phase, the destination, the sources, which unit produces each pending source, and whether each source is ready. A register table records the unit that will write each register. Operand fetch and completion happen out of program order. A write-back is delayed while an older reader still needs the value it would overwrite, so read-after-write, write-after-write and write-after-read hazards are all resolved at run time.

Top module: `sb_ctrl`

## Requirements
- R1: After reset no unit is busy, `rd_grant` and `wb_grant` are zero, and `iss_ready` is 1 for any unit and destination.
- R2: `iss_ready` is 0 while the unit selected by `iss_fu` is busy. An instruction is taken only in a cycle where `iss_valid` and `iss_ready` are both 1.
- R3: `iss_ready` is 0 while the register on `iss_dst` is reserved by any unit. A reservation is taken on issue and released at the edge that closes that register's write-back cycle.
- R4: A unit gets an operand-fetch grant only once neither of its sources has a pending producer. A source whose producer writes back becomes ready at the edge that closes that write-back cycle.
- R5: At most RD_PORTS (default 2) units receive `rd_grant` in one cycle. Eligible units are served lowest index first, and the rest wait.
- R6: A unit granted its operand fetch in cycle t with latency L (L ≥ 1) becomes eligible for write-back in cycle t+1+L.
- R7: At most one bit of `wb_grant` is set per cycle, and it goes to the lowest eligible unit index. `wb_reg` then carries that unit's destination register.
- R8: A finished unit is held from write-back while another unit has not yet received its operand-fetch grant and has a ready source that names the finished unit's destination register.
- R9: `busy` of a unit falls at the edge that closes its write-back cycle, so a new instruction may issue to it in the next cycle.
- R10: An issued latency of 0 behaves exactly like a latency of 1.
- R11: An instruction that issues in the same cycle as the write-back of one of its sources treats that source as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction is presented at the issue port |
| iss_fu | input | $clog2(NFU) | Target function unit |
| iss_dst | input | $clog2(NREG) | Destination register |
| iss_src1 | input | $clog2(NREG) | First source register |
| iss_src2 | input | $clog2(NREG) | Second source register |
| iss_lat | input | LAT_W | Execution latency in cycles (0 is taken as 1) |
| iss_ready | output | 1 | The presented instruction is accepted if valid |
| rd_grant | output | NFU | Units allowed to fetch operands this cycle |
| wb_grant | output | NFU | Unit allowed to write its result this cycle (one-hot or zero) |
| wb_reg | output | $clog2(NREG) | Register written by the granted unit |
| busy | output | NFU | Units holding an instruction |

## Verification
The hardest case to reach from the ports is the write-after-read hold. It needs three instructions in flight together: a long-latency producer, a reader that has captured one source as ready but is stalled on the other, and a short instruction that finishes early and wants to overwrite the ready source. A directed sequence builds exactly this case, with latency 8 on the producer and latency 1 on the overwriting unit. The bench then checks that the overwriting write-back comes strictly after the stalled reader's fetch grant. Long constrained-random runs on only eight registers also produce many busy-unit stalls, reservation stalls, same-cycle write-and-issue coincidences and port contention. A cycle model built from the requirements checks every output in every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

   // Per-unit progress through the instruction lifetime.
   typedef enum logic [1:0] {
      PH_IDLE     = 2'd0,
      PH_WAIT_OPS = 2'd1,
      PH_EXEC     = 2'd2,
      PH_WAIT_WB  = 2'd3
   } sb_phase_e;

endpackage

// File: rtl/sb_arbiter.sv
module sb_arbiter #(
   parameter int N      = 4,
   parameter int GRANTS = 1
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   generate
      if (GRANTS < 1 || GRANTS > N) begin : g_bad_grants
         $error("sb_arbiter: GRANTS must lie in 1..N");
      end

      if (GRANTS == 1) begin : g_single
         localparam logic [N-1:0] ONE = N'(1);
         // Isolate the lowest set request bit.
         assign gnt = req & ((~req) + ONE);
      end else begin : g_multi
         always_comb begin
            int taken;
            taken = 0;
            gnt   = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i] && taken < GRANTS) begin
                  gnt[i] = 1'b1;
                  taken++;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sb_reg_table.sv
module sb_reg_table #(
   parameter int NREG = 8,
   parameter int NFU  = 4,
   localparam int REG_W = $clog2(NREG),
   localparam int FU_W  = $clog2(NFU)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [REG_W-1:0] set_reg,
   input  logic [FU_W-1:0]  set_fu,
   input  logic             clr_en,
   input  logic [REG_W-1:0] clr_reg,
   output logic [NREG-1:0]  pend,
   output logic [FU_W-1:0]  owner [NREG]
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         for (int r = 0; r < NREG; r++) owner[r] <= '0;
      end else begin
         for (int r = 0; r < NREG; r++) begin
            if (clr_en && clr_reg == REG_W'(r)) pend[r] <= 1'b0;
            if (set_en && set_reg == REG_W'(r)) begin
               pend[r]  <= 1'b1;
               owner[r] <= set_fu;
            end
         end
      end
   end

   // R3: a register is never reserved twice.
   p_waw_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> !pend[set_reg]);

   // R7: only a reserved register is released by a write-back.
   p_clr_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> pend[clr_reg]);

endmodule

// File: rtl/sb_unit.sv
module sb_unit #(
   parameter int NFU   = 4,
   parameter int NREG  = 8,
   parameter int LAT_W = 4,
   localparam int FU_W  = $clog2(NFU),
   localparam int REG_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_en,
   input  logic [REG_W-1:0]  iss_dst,
   input  logic [REG_W-1:0]  iss_s1,
   input  logic [REG_W-1:0]  iss_s2,
   input  logic [FU_W-1:0]   iss_q1,
   input  logic [FU_W-1:0]   iss_q2,
   input  logic              iss_r1,
   input  logic              iss_r2,
   input  logic [LAT_W-1:0]  iss_lat,
   input  logic              rd_gnt,
   input  logic              wb_gnt,
   input  logic              bc_valid,
   input  logic [FU_W-1:0]   bc_fu,
   output sb_pkg::sb_phase_e phase,
   output logic              busy,
   output logic [REG_W-1:0]  dst,
   output logic [REG_W-1:0]  s1,
   output logic [REG_W-1:0]  s2,
   output logic              r1,
   output logic              r2
);
   import sb_pkg::*;

   logic [FU_W-1:0]  q1, q2;
   logic [LAT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         dst   <= '0;
         s1    <= '0;
         s2    <= '0;
         q1    <= '0;
         q2    <= '0;
         r1    <= 1'b0;
         r2    <= 1'b0;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (iss_en) begin
               phase <= PH_WAIT_OPS;
               dst   <= iss_dst;
               s1    <= iss_s1;
               s2    <= iss_s2;
               q1    <= iss_q1;
               q2    <= iss_q2;
               r1    <= iss_r1;
               r2    <= iss_r2;
               cnt   <= (iss_lat == '0) ? LAT_W'(1) : iss_lat;
            end
            PH_WAIT_OPS: begin
               if (bc_valid && !r1 && q1 == bc_fu) r1 <= 1'b1;
               if (bc_valid && !r2 && q2 == bc_fu) r2 <= 1'b1;
               if (rd_gnt) phase <= PH_EXEC;
            end
            PH_EXEC: begin
               if (cnt == LAT_W'(1)) phase <= PH_WAIT_WB;
               else                  cnt   <= cnt - LAT_W'(1);
            end
            PH_WAIT_WB: if (wb_gnt) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy = (phase != PH_IDLE);

   // R2: issue only lands on a free unit.
   p_issue_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_en |-> !busy);

   // R4: a fetch grant only reaches a unit whose sources are all ready.
   p_fetch_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gnt |-> (phase == PH_WAIT_OPS && r1 && r2));

   // R7: a write-back grant only reaches a unit that has finished.
   p_wb_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_gnt |-> phase == PH_WAIT_WB);

   // R9: the unit is free right after its write-back.
   p_free_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_gnt |=> !busy);

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
   parameter int NFU      = 4,
   parameter int NREG     = 8,
   parameter int RD_PORTS = 2,
   parameter int LAT_W    = 4,
   localparam int FU_W  = $clog2(NFU),
   localparam int REG_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iss_valid,
   input  logic [FU_W-1:0]  iss_fu,
   input  logic [REG_W-1:0] iss_dst,
   input  logic [REG_W-1:0] iss_src1,
   input  logic [REG_W-1:0] iss_src2,
   input  logic [LAT_W-1:0] iss_lat,
   output logic             iss_ready,
   output logic [NFU-1:0]   rd_grant,
   output logic [NFU-1:0]   wb_grant,
   output logic [REG_W-1:0] wb_reg,
   output logic [NFU-1:0]   busy
);
   import sb_pkg::*;

   generate
      if (NFU < 2 || (1 << FU_W) != NFU) begin : g_bad_nfu
         $error("sb_ctrl: NFU must be a power of two, at least 2");
      end
      if (NREG < 2 || (1 << REG_W) != NREG) begin : g_bad_nreg
         $error("sb_ctrl: NREG must be a power of two, at least 2");
      end
      if (RD_PORTS < 1 || RD_PORTS > NFU) begin : g_bad_ports
         $error("sb_ctrl: RD_PORTS must lie in 1..NFU");
      end
      if (LAT_W < 1) begin : g_bad_lat
         $error("sb_ctrl: LAT_W must be at least 1");
      end
   endgenerate

   // Register reservation table.
   logic [NREG-1:0] pend;
   logic [FU_W-1:0] owner [NREG];

   // Per-unit state brought out of the unit instances.
   sb_phase_e        phase_a [NFU];
   logic [REG_W-1:0] dst_a   [NFU];
   logic [REG_W-1:0] s1_a    [NFU];
   logic [REG_W-1:0] s2_a    [NFU];
   logic [NFU-1:0]   r1_v, r2_v;

   logic [NFU-1:0]   rd_req, wb_req, war_hold;
   logic             wb_valid;
   logic [FU_W-1:0]  wb_fu;
   logic             accept;
   logic             s1_wait, s2_wait;

   // Write-back broadcast: which unit writes this cycle.
   always_comb begin
      wb_fu = '0;
      for (int i = 0; i < NFU; i++)
         if (wb_grant[i]) wb_fu = FU_W'(i);
   end
   assign wb_valid = |wb_grant;
   assign wb_reg   = dst_a[wb_fu];

   // Issue check: free unit and unreserved destination.
   assign iss_ready = !busy[iss_fu] && !pend[iss_dst];
   assign accept    = iss_valid && iss_ready;

   // A source whose producer writes back in this very cycle is already ready.
   assign s1_wait = pend[iss_src1] && !(wb_valid && owner[iss_src1] == wb_fu);
   assign s2_wait = pend[iss_src2] && !(wb_valid && owner[iss_src2] == wb_fu);

   sb_reg_table #(.NREG(NREG), .NFU(NFU)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (accept),
      .set_reg (iss_dst),
      .set_fu  (iss_fu),
      .clr_en  (wb_valid),
      .clr_reg (wb_reg),
      .pend    (pend),
      .owner   (owner)
   );

   generate
      for (genvar u = 0; u < NFU; u++) begin : g_unit
         sb_unit #(.NFU(NFU), .NREG(NREG), .LAT_W(LAT_W)) u_fu (
            .clk      (clk),
            .rst_n    (rst_n),
            .iss_en   (accept && iss_fu == FU_W'(u)),
            .iss_dst  (iss_dst),
            .iss_s1   (iss_src1),
            .iss_s2   (iss_src2),
            .iss_q1   (owner[iss_src1]),
            .iss_q2   (owner[iss_src2]),
            .iss_r1   (!s1_wait),
            .iss_r2   (!s2_wait),
            .iss_lat  (iss_lat),
            .rd_gnt   (rd_grant[u]),
            .wb_gnt   (wb_grant[u]),
            .bc_valid (wb_valid),
            .bc_fu    (wb_fu),
            .phase    (phase_a[u]),
            .busy     (busy[u]),
            .dst      (dst_a[u]),
            .s1       (s1_a[u]),
            .s2       (s2_a[u]),
            .r1       (r1_v[u]),
            .r2       (r2_v[u])
         );

         assign rd_req[u] = (phase_a[u] == PH_WAIT_OPS) && r1_v[u] && r2_v[u];
         assign wb_req[u] = (phase_a[u] == PH_WAIT_WB) && !war_hold[u];
      end
   endgenerate

   // Write-after-read guard: an unfetched, ready source still names our target.
   always_comb begin
      war_hold = '0;
      for (int w = 0; w < NFU; w++) begin
         for (int v = 0; v < NFU; v++) begin
            if (v != w && phase_a[v] == PH_WAIT_OPS &&
                ((s1_a[v] == dst_a[w] && r1_v[v]) ||
                 (s2_a[v] == dst_a[w] && r2_v[v])))
               war_hold[w] = 1'b1;
         end
      end
   end

   sb_arbiter #(.N(NFU), .GRANTS(RD_PORTS)) u_rd_arb (
      .req (rd_req),
      .gnt (rd_grant)
   );

   sb_arbiter #(.N(NFU), .GRANTS(1)) u_wb_arb (
      .req (wb_req),
      .gnt (wb_grant)
   );

   // R7: a single write-back per cycle.
   p_one_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wb_grant));

   // R5: fetch grants stay within the read-port budget.
   p_rd_ports_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rd_grant) <= RD_PORTS);

   // R3: a written register is free for issue in the next cycle.
   p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !pend[$past(wb_reg)]);

endmodule

// File: tb/tb_sb_ctrl.sv
module tb_sb_ctrl;

   localparam int CLK_P    = 10;
   localparam int NFU      = 4;
   localparam int NREG     = 8;
   localparam int RD_PORTS = 2;
   localparam int LAT_W    = 4;
   localparam int FU_W     = $clog2(NFU);
   localparam int REG_W    = $clog2(NREG);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             iss_valid = 1'b0;
   logic [FU_W-1:0]  iss_fu = '0;
   logic [REG_W-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
   logic [LAT_W-1:0] iss_lat = '0;
   logic             iss_ready;
   logic [NFU-1:0]   rd_grant, wb_grant, busy;
   logic [REG_W-1:0] wb_reg;

   always #(CLK_P/2) clk = ~clk;

   sb_ctrl #(.NFU(NFU), .NREG(NREG), .RD_PORTS(RD_PORTS), .LAT_W(LAT_W)) dut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_fu(iss_fu),
      .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
      .iss_lat(iss_lat), .iss_ready(iss_ready), .rd_grant(rd_grant),
      .wb_grant(wb_grant), .wb_reg(wb_reg), .busy(busy)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   // Reference model state (0 idle, 1 waiting operands, 2 executing, 3 finished).
   int m_ph [NFU], m_dst [NFU], m_s1 [NFU], m_s2 [NFU];
   int m_q1 [NFU], m_q2 [NFU], m_r1 [NFU], m_r2 [NFU], m_cnt [NFU];
   int m_rv [NREG], m_rf [NREG];
   int last_rd [NFU], last_wb [NFU];

   bit            e_ready;
   bit [NFU-1:0]  e_rd, e_wb, e_busy;
   int            e_reg, e_wbu;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int u = 0; u < NFU; u++) begin
         m_ph[u] = 0; m_dst[u] = 0; m_s1[u] = 0; m_s2[u] = 0; m_q1[u] = 0;
         m_q2[u] = 0; m_r1[u] = 0; m_r2[u] = 0; m_cnt[u] = 0;
         last_rd[u] = -1; last_wb[u] = -1;
      end
      for (int r = 0; r < NREG; r++) begin m_rv[r] = 0; m_rf[r] = 0; end
   endtask

   function automatic bit war_blocked(int w);
      for (int v = 0; v < NFU; v++)
         if (v != w && m_ph[v] == 1 &&
             ((m_s1[v] == m_dst[w] && m_r1[v] != 0) || (m_s2[v] == m_dst[w] && m_r2[v] != 0)))
            return 1'b1;
      return 1'b0;
   endfunction

   task automatic model_eval();
      int n;
      e_ready = (m_ph[int'(iss_fu)] == 0) && (m_rv[int'(iss_dst)] == 0);
      e_rd = '0; e_wb = '0; e_wbu = -1; e_reg = 0; n = 0;
      for (int u = 0; u < NFU; u++) begin
         e_busy[u] = (m_ph[u] != 0);
         if (m_ph[u] == 1 && m_r1[u] != 0 && m_r2[u] != 0 && n < RD_PORTS) begin
            e_rd[u] = 1'b1; n++;
         end
         if (e_wbu < 0 && m_ph[u] == 3 && !war_blocked(u)) begin
            e_wb[u] = 1'b1; e_wbu = u; e_reg = m_dst[u];
         end
      end
   endtask

   task automatic model_step();
      int f, s1, s2, l;
      for (int u = 0; u < NFU; u++) begin
         case (m_ph[u])
            1: begin
               if (e_wbu >= 0 && m_r1[u] == 0 && m_q1[u] == e_wbu) m_r1[u] = 1;
               if (e_wbu >= 0 && m_r2[u] == 0 && m_q2[u] == e_wbu) m_r2[u] = 1;
               if (e_rd[u]) m_ph[u] = 2;
            end
            2: if (m_cnt[u] == 1) m_ph[u] = 3; else m_cnt[u]--;
            3: if (e_wbu == u) m_ph[u] = 0;
            default: ;
         endcase
      end
      if (iss_valid && e_ready) begin
         f = int'(iss_fu); s1 = int'(iss_src1); s2 = int'(iss_src2); l = int'(iss_lat);
         m_ph[f] = 1; m_dst[f] = int'(iss_dst); m_s1[f] = s1; m_s2[f] = s2;
         // R11: a source written back this cycle counts as ready.
         m_r1[f] = (m_rv[s1] != 0 && !(e_wbu >= 0 && m_rf[s1] == e_wbu)) ? 0 : 1;
         m_r2[f] = (m_rv[s2] != 0 && !(e_wbu >= 0 && m_rf[s2] == e_wbu)) ? 0 : 1;
         m_q1[f] = m_rf[s1]; m_q2[f] = m_rf[s2];
         m_cnt[f] = (l == 0) ? 1 : l;   // R10
         m_rv[int'(iss_dst)] = 1; m_rf[int'(iss_dst)] = f;
      end
      if (e_wbu >= 0) m_rv[e_reg] = 0;
   endtask

   // One clock: drive at the falling edge, compare just before the rising edge.
   task automatic cycle(bit v, int fu, int dst, int s1, int s2, int lat);
      @(negedge clk);
      iss_valid = v; iss_fu = FU_W'(fu); iss_dst = REG_W'(dst);
      iss_src1 = REG_W'(s1); iss_src2 = REG_W'(s2); iss_lat = LAT_W'(lat);
      #(CLK_P/2 - 1);
      model_eval();
      chk(iss_ready == e_ready, "R2 R3 issue acceptance", int'(iss_ready), int'(e_ready));
      chk(rd_grant == e_rd, "R4 R5 R6 R11 operand fetch grant", int'(rd_grant), int'(e_rd));
      chk(wb_grant == e_wb, "R6 R7 R8 R10 write-back grant", int'(wb_grant), int'(e_wb));
      if (e_wbu >= 0)
         chk(int'(wb_reg) == e_reg, "R7 write-back register", int'(wb_reg), e_reg);
      chk(busy == e_busy, "R9 busy flags", int'(busy), int'(e_busy));
      for (int u = 0; u < NFU; u++) begin
         if (rd_grant[u]) last_rd[u] = cyc;
         if (wb_grant[u]) last_wb[u] = cyc;
      end
      model_step();
      cyc++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, actual=%0d expected=%0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: quiet state after reset.
      chk(busy == '0, "R1 busy after reset", int'(busy), 0);
      chk(rd_grant == '0, "R1 fetch grant after reset", int'(rd_grant), 0);
      chk(wb_grant == '0, "R1 write-back grant after reset", int'(wb_grant), 0);
      iss_valid = 1'b1; iss_fu = 2'd3; iss_dst = 3'd7; #1;
      chk(iss_ready == 1'b1, "R1 issue ready after reset", int'(iss_ready), 1);
      iss_valid = 1'b0;

      // Directed R8 case: long producer of r5, reader stalled on r5 with r3 ready,
      // short unit overwriting r3 must wait for the reader's fetch.
      cycle(1, 0, 5, 0, 0, 8);
      cycle(1, 1, 6, 5, 3, 1);
      cycle(1, 2, 3, 0, 0, 1);
      for (int i = 0; i < 30; i++) cycle(0, 0, 0, 0, 0, 0);
      chk(last_rd[1] >= 0 && last_wb[2] > last_rd[1], "R8 overwrite after old-value fetch",
          last_wb[2], last_rd[1] + 1);

      // Directed R11/R3 case: issue reading a register in the cycle it is written back.
      cycle(1, 0, 2, 0, 0, 1);
      cycle(0, 0, 0, 0, 0, 0);
      cycle(0, 0, 0, 0, 0, 0);
      cycle(1, 1, 4, 2, 2, 0);
      cycle(1, 2, 2, 1, 1, 2);
      for (int i = 0; i < 12; i++) cycle(0, 0, 0, 0, 0, 0);

      // Constrained random mix, small register file for dense hazards.
      for (int i = 0; i < 4000; i++)
         cycle($urandom_range(0, 99) < 65, $urandom_range(0, NFU-1),
               $urandom_range(0, NREG-1), $urandom_range(0, NREG-1),
               $urandom_range(0, NREG-1), $urandom_range(0, 5));

      for (int i = 0; i < 80; i++) cycle(0, 0, 0, 0, 0, 0);
      chk(busy == '0, "R9 all units drained", int'(busy), 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule